// File: doc/BRIEF.md
# Ring Sampler Trigger and Readout Sequencer

This block is the digital controller for a circular analog sampling array. Each channel of the array is a ring of cells. A sampling wave runs around the ring without pause until an event is captured. When a trigger arrives, the sequencer keeps the wave running for a programmable number of cycles. It then halts the wave and latches the cell position reported by the array at that moment.

After the stop, a readout token walks every cell of each selected channel, one cell per readout-clock cycle. The walk begins at the cell after the stop position and wraps around the ring, so each channel's samples come out oldest first. Channels are taken in ascending order through an analog multiplexer. Unselected channels cost no cycles.

Each token step drives the multiplexer select and the cell index. One cycle later, an ADC strobe fires together with a sample-valid tag that names the channel and cell being converted. When the last cell has been strobed, a done pulse is issued and sampling restarts by itself. Of the ten channels, indices 8 and 9 carry calibration signals such as a timing reference; they are read exactly like data channels.

Top module: `ring_readout_seq`

## Requirements
- R1: During reset `wave_en`, `token_shift`, `adc_strobe`, `smp_valid` and `done` are low and `busy` is high. In the first cycle after reset is released, the block enters sampling: `wave_en` is high and `busy` is low.
- R2: `trig` is sampled high on a clock edge while sampling. From that edge, `wave_en` stays high for exactly `latency`+1 cycles, with `busy` high during those cycles, and then goes low.
- R3: The `wave_pos` value sampled on the last edge at which `wave_en` was high is latched as the stop cell. Each channel's readout starts at cell (stop+1) mod CELLS and advances by one per token step, wrapping from CELLS-1 to 0.
- R4: Only channels whose bit is set in `chan_mask` are read. Bit i of `chan_mask` selects channel i, and `mux_sel` carries i. Channels are read in ascending index, each for exactly CELLS consecutive token steps, with no idle cycle between channels.
- R5: A trigger raised while `busy` is high outside the latency wait has no effect. After the event completes, sampling continues and no further readout starts without a new trigger.
- R6: `adc_strobe` and `smp_valid` are high exactly one cycle after each `token_shift` cycle. `smp_chan`/`smp_cell` then equal the `mux_sel`/`cell_idx` of that token step.
- R7: `done` is a one-cycle pulse that coincides with the strobe of the last cell of the last enabled channel. `wave_en` is high again in the following cycle.
- R8: With an all-zero `chan_mask`, the stop is followed by a `done` pulse with no token step or strobe, and sampling then resumes.
- R9: `busy` is low exactly when the block is sampling and waiting for a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Event trigger |
| latency | input | LAT_W | Extra cycles the wave runs after the trigger edge |
| chan_mask | input | CHANNELS | Channel selection, bit i selects channel i |
| wave_pos | input | log2(CELLS) | Current wave cell reported by the array |
| wave_en | output | 1 | Sampling wave enable |
| busy | output | 1 | High whenever not sampling and waiting for a trigger |
| token_shift | output | 1 | Readout token steps this cycle |
| mux_sel | output | log2(CHANNELS) | Analog multiplexer channel select |
| cell_idx | output | log2(CELLS) | Cell addressed by the token |
| adc_strobe | output | 1 | ADC conversion strobe |
| smp_valid | output | 1 | Sample tag valid |
| smp_chan | output | log2(CHANNELS) | Channel of the converted sample |
| smp_cell | output | log2(CELLS) | Cell of the converted sample |
| done | output | 1 | Readout complete pulse |

## Verification
The assertions assume that `wave_pos` stays below CELLS. They also assume that `chan_mask` and `latency` are stable while they are latched, and that CELLS is a power of two so that cell indices wrap naturally. The bench stub advances `wave_pos` only while `wave_en` is high and wraps it modulo CELLS. It changes `latency` and `chan_mask` only while the block is idle in sampling, before it raises the trigger. Triggers during readout are driven on purpose, so that the ignore rule is exercised inside these assumptions.

// File: rtl/ring_readout_seq.sv
module ring_readout_seq #(
  parameter int CELLS    = 1024,
  parameter int CHANNELS = 10,
  parameter int LAT_W    = 8,
  localparam int CW      = $clog2(CELLS),
  localparam int CHW     = $clog2(CHANNELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig,
  input  logic [LAT_W-1:0]    latency,
  input  logic [CHANNELS-1:0] chan_mask,
  input  logic [CW-1:0]       wave_pos,
  output logic                wave_en,
  output logic                busy,
  output logic                token_shift,
  output logic [CHW-1:0]      mux_sel,
  output logic [CW-1:0]       cell_idx,
  output logic                adc_strobe,
  output logic                smp_valid,
  output logic [CHW-1:0]      smp_chan,
  output logic [CW-1:0]       smp_cell,
  output logic                done
);

  typedef enum logic [2:0] {S_IDLE, S_SAMP, S_LAT, S_STOP, S_READ} st_t;

  st_t                 state;
  logic [LAT_W-1:0]    cnt;
  logic [CW-1:0]       stop_q, cell_q, ncell;
  logic [CHANNELS-1:0] mask_q;
  logic [CHW-1:0]      ch_q;
  logic [CHW:0]        nxt;

  function automatic logic [CHW:0] first_above(input logic [CHANNELS-1:0] m, input int from);
    logic [CHW:0] r;
    r = '0;
    for (int i = CHANNELS - 1; i >= 0; i--)
      if (m[i] && i > from) r = {1'b1, CHW'(i)};
    return r;
  endfunction

  always_comb nxt = first_above(mask_q, (state == S_READ) ? int'(ch_q) : -1);

  assign wave_en     = (state == S_SAMP) || (state == S_LAT);
  assign busy        = (state != S_SAMP);
  assign token_shift = (state == S_READ);
  assign mux_sel     = ch_q;
  assign cell_idx    = cell_q;
  assign smp_valid   = adc_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      stop_q     <= '0;
      mask_q     <= '0;
      ch_q       <= '0;
      cell_q     <= '0;
      ncell      <= '0;
      adc_strobe <= 1'b0;
      smp_chan   <= '0;
      smp_cell   <= '0;
      done       <= 1'b0;
    end else begin
      adc_strobe <= token_shift;
      smp_chan   <= ch_q;
      smp_cell   <= cell_q;
      done       <= 1'b0;
      case (state)
        S_IDLE: state <= S_SAMP;
        S_SAMP: if (trig) begin
          cnt   <= latency;
          state <= S_LAT;
        end
        S_LAT: if (cnt == '0) begin
          stop_q <= wave_pos;
          mask_q <= chan_mask;
          state  <= S_STOP;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_STOP: if (nxt[CHW]) begin
          ch_q   <= nxt[CHW-1:0];
          cell_q <= stop_q + 1'b1;
          ncell  <= '0;
          state  <= S_READ;
        end else begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_READ: begin
          cell_q <= cell_q + 1'b1;
          ncell  <= ncell + 1'b1;
          if (ncell == CW'(CELLS - 1)) begin
            if (nxt[CHW]) begin
              ch_q   <= nxt[CHW-1:0];
              cell_q <= stop_q + 1'b1;
              ncell  <= '0;
            end else begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Requirement R2
  a_r2_wave_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LAT && cnt != '0) |=> wave_en && busy);

  // Requirement R3
  a_r3_cell_step: assert property (@(posedge clk) disable iff (!rst_n)
    (token_shift && $past(token_shift) && mux_sel == $past(mux_sel))
      |-> cell_idx == CW'($past(cell_idx) + 1'b1));

  // Requirement R4
  a_r4_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    token_shift |-> mask_q[mux_sel]);

  // Requirement R5
  a_r5_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP || state == S_READ) |=> state != S_LAT);

  // Requirement R6
  a_r6_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    token_shift |=> adc_strobe && smp_valid && smp_cell == $past(cell_idx)
      && smp_chan == $past(mux_sel));

  // Requirement R7
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && wave_en);

  // Requirement R8
  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && mask_q == '0) |=> done && !token_shift);

  // Requirement R9
  a_r9_busy_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_en |-> busy);

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({token_shift, wave_en}));

endmodule

// File: tb/test_ring_readout_seq.sv
`timescale 1ns/1ps
module test_ring_readout_seq;
  localparam int CELLS = 1024;
  localparam int CH    = 10;
  localparam int CW    = $clog2(CELLS);
  localparam int CHW   = $clog2(CH);

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
  logic [7:0]    latency = '0;
  logic [CH-1:0] chan_mask = '0;
  logic [CW-1:0] wave_pos = CW'(1000);
  logic wave_en, busy, token_shift, adc_strobe, smp_valid, done;
  logic [CHW-1:0] mux_sel, smp_chan;
  logic [CW-1:0]  cell_idx, smp_cell;

  int nchk = 0, nerr = 0, done_cnt = 0;
  bit finished = 0, rd_active = 0;
  logic [CHW+CW-1:0] expq[$];
  logic prev_shift = 1'b0;
  logic [CHW-1:0] prev_chan = '0;
  logic [CW-1:0]  prev_cell = '0;

  always #2.5 clk = ~clk;

  ring_readout_seq i_ring_readout_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .latency(latency), .chan_mask(chan_mask),
    .wave_pos(wave_pos), .wave_en(wave_en), .busy(busy), .token_shift(token_shift),
    .mux_sel(mux_sel), .cell_idx(cell_idx), .adc_strobe(adc_strobe), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_cell(smp_cell), .done(done));

  // array stub: the wave advances while enabled
  always @(posedge clk) if (wave_en) wave_pos <= wave_pos + 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every converted sample
  always @(negedge clk) if (rst_n) begin
    if (adc_strobe) begin
      check(prev_shift && smp_chan == prev_chan && smp_cell == prev_cell && smp_valid,
            "R6 strobe tag", {smp_chan, smp_cell}, {prev_chan, prev_cell});
      if (expq.size() == 0) check(0, "R4 unexpected sample", {smp_chan, smp_cell}, -1);
      else begin
        logic [CHW+CW-1:0] e;
        e = expq.pop_front();
        check({smp_chan, smp_cell} == e, "R3/R4 sample order", {smp_chan, smp_cell}, e);
      end
      rd_active = 1;
    end else if (rd_active && !done) begin
      check(0, "R4 gap in readout", 0, 1);
      rd_active = 0;
    end
    if (done) begin
      check(expq.size() == 0, "R7 queue empty at done", expq.size(), 0);
      check(!rd_active || adc_strobe, "R7 done with last strobe", adc_strobe, 1);
      rd_active = 0;
      done_cnt++;
    end
    prev_shift = token_shift;
    prev_chan  = mux_sel;
    prev_cell  = cell_idx;
  end

  task automatic run_event(input logic [CH-1:0] m, input logic [7:0] lat, input bit poke);
    int n, d0;
    logic [CW-1:0] last;
    while (!(wave_en && !busy)) @(negedge clk);
    check(!busy, "R9 idle sampling", busy, 0);
    latency = lat; chan_mask = m; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    n = 0; last = '0;
    while (wave_en) begin
      check(busy, "R2 busy in latency", busy, 1);
      last = wave_pos; n++;
      @(negedge clk);
    end
    check(n == int'(lat) + 1, "R2 latency cycles", n, int'(lat) + 1);
    check(busy, "R9 busy when stopped", busy, 1);
    d0 = done_cnt;
    for (int c = 0; c < CH; c++)
      if (m[c]) for (int k = 0; k < CELLS; k++)
        expq.push_back({CHW'(c), CW'(last + 1 + k)});
    if (poke) begin
      repeat (5) @(negedge clk);
      trig = 1'b1; @(negedge clk); trig = 1'b0;
    end
    if (m == '0) begin
      n = 0;
      while (done_cnt == d0) begin
        check(!token_shift && !adc_strobe, "R8 no readout", token_shift, 0);
        n++; @(negedge clk);
      end
    end else
      while (done_cnt == d0) @(negedge clk);
    check(wave_en && !busy, "R7 sampling resumes", wave_en, 1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!wave_en || token_shift) check(0, "R5 trigger ignored", token_shift, 0);
    end
    check(wave_en && !busy, "R5 still sampling", wave_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!wave_en && busy && !token_shift && !adc_strobe && !smp_valid && !done,
          "R1 reset state", {wave_en, busy, token_shift, adc_strobe, done}, 5'b01000);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(wave_en && !busy, "R1 sampling after reset", wave_en, 1);
    run_event(10'h3FF, 8'd5, 1'b1);
    run_event(10'b10_0000_0001, 8'd0, 1'b1);
    run_event(10'h000, 8'd3, 1'b0);
    run_event(10'b01_0010_0110, 8'd17, 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule